// File: doc/BRIEF.md
# Shadow Stack Push / Pop-Check Unit

This unit owns the shadow stack pointer of a processor that protects return addresses with a second, hardware-guarded stack. It carries out three operations on request: push, which stores a return-address register just below the pointer and then moves the pointer down by one word; pop-check, which loads the word at the pointer, compares it with a return-address register, and moves the pointer up only when the two agree; and read-pointer, which returns the pointer value. A mismatch on pop-check raises a dedicated software-check fault. That fault is how a corrupted return address is caught.

Whether the operations take effect depends on the current privilege level and two environment-config enable bits. When the derived enable is clear, push and pop-check complete without touching memory, and read-pointer returns zero. The unit talks to already-translated memory through a single-beat request/response port. It reports access faults with the faulting address, and it accepts one operation at a time under a busy/done handshake. Software may load the pointer through a separate write port while the unit is idle.

Top module: `sstk_unit`

## Requirements
- R1: The enable is 0 in machine mode (priv 2'b11). In supervisor mode (priv 2'b01) it equals `menv_sse`. In user mode (priv 2'b00) it equals `senv_sse` when parameter HAS_SMODE is 1, and 0 otherwise. The unused code 2'b10 gives 0.
- R2: A push or pop-check with a legal source and the enable clear asserts `done` in the cycle after acceptance. It raises no fault, issues no memory request and leaves `ssp_o` unchanged.
- R3: A read-pointer (op_req bit 2) asserts `done` in the cycle after acceptance. `result` then holds `ssp_o` when enabled and 0 otherwise, and `src_idx` is ignored.
- R4: An enabled push (op_req bit 0) issues a write of `src_val` with `mem_we`=1 at address ssp − XLEN/8. After a fault-free response, `ssp_o` becomes that address in the same cycle that `done` rises, one cycle after the response.
- R5: An enabled pop-check (op_req bit 1) reads at address ssp. If the returned word equals `src_val`, `ssp_o` increases by XLEN/8. Otherwise `fault_swchk` is raised and `ssp_o` is unchanged.
- R6: The access address is misaligned when its low log2(XLEN/8) bits are not zero. A misaligned address raises `fault_access`, puts that address on `fault_addr` and asserts `done` one cycle after acceptance. No memory request is issued.
- R7: A push or pop-check whose `src_idx` is neither 1 nor 5 raises `fault_illegal` with `done` one cycle after acceptance. This check applies whatever the enable. The operation makes no memory access and leaves `ssp_o` unchanged.
- R8: A response with `mem_err`=1 raises `fault_access` and puts the request address on `fault_addr`. `ssp_o` is left unchanged.
- R9: An operation is accepted when `op_req` is nonzero and `busy` is low. `busy` stays high until the response. `mem_req` and its address stay stable until `mem_rsp`, and `op_req` is ignored while busy.
- R10: Reset clears `ssp_o`, `busy`, `done` and `mem_req`. A `csr_we` pulse while idle, with no request, loads `csr_wdata` into `ssp_o` on the next edge. A pulse while busy is ignored.
- R11: A push of a value followed by a pop-check of the same value returns `ssp_o` to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_req | input | 3 | One-hot request: bit0 push, bit1 pop-check, bit2 read-pointer |
| src_idx | input | 5 | Source register index of push / pop-check |
| src_val | input | XLEN | Source register value |
| priv | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| menv_sse | input | 1 | Machine-level shadow-stack enable bit |
| senv_sse | input | 1 | Supervisor-level shadow-stack enable bit |
| csr_we | input | 1 | Pointer write strobe |
| csr_wdata | input | XLEN | Pointer write value |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| result | output | XLEN | Read-pointer result |
| ssp_o | output | XLEN | Current shadow stack pointer |
| fault_access | output | 1 | Access fault (misaligned or memory error), valid with done |
| fault_swchk | output | 1 | Shadow-stack check fault, valid with done |
| fault_illegal | output | 1 | Illegal source register, valid with done |
| fault_addr | output | XLEN | Faulting address, valid with fault_access |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | XLEN | Memory address |
| mem_wdata | output | XLEN | Write data |
| mem_rsp | input | 1 | Memory response strobe |
| mem_rdata | input | XLEN | Read data |
| mem_err | input | 1 | Memory error, valid with mem_rsp |

## Verification
The assertions take three things for granted about the inputs. `op_req` never has more than one bit set. `mem_rsp` arrives only while a request is pending and lasts a single cycle. `priv` uses the three defined codes. The stimulus keeps to these rules: it issues each operation as a single one-hot pulse and waits for `done` before the next one. Its memory model answers each request exactly once, one cycle after seeing it, and drops its response strobe before the request can be seen again.

// File: rtl/sstk_pkg.sv
package sstk_pkg;

    localparam int OP_W      = 3;
    localparam int OP_PUSH   = 0;
    localparam int OP_POPCHK = 1;
    localparam int OP_RDPTR  = 2;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    typedef struct packed {
        logic access;
        logic swchk;
        logic illegal;
    } fault_t;

    // Only the two link registers may feed push / pop-check
    function automatic logic link_reg_ok(input logic [4:0] idx);
        return (idx == 5'd1) || (idx == 5'd5);
    endfunction

endpackage

// File: rtl/sstk_enable.sv
module sstk_enable
    import sstk_pkg::*;
#(
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic [1:0] priv,
    input  logic       menv_sse,
    input  logic       senv_sse,
    output logic       en
);
    always_comb begin
        unique case (priv_e'(priv))
            PRIV_SUPER: en = menv_sse;
            PRIV_USER:  en = HAS_SMODE ? senv_sse : 1'b0;
            default:    en = 1'b0;
        endcase
    end
endmodule

// File: rtl/sstk_addr.sv
module sstk_addr #(
    parameter int XLEN = 32
) (
    input  logic            is_push,
    input  logic [XLEN-1:0] ssp,
    output logic [XLEN-1:0] acc_addr,
    output logic            acc_mis
);
    localparam int BYTES = XLEN / 8;
    localparam int AL    = $clog2(BYTES);

    always_comb begin
        acc_addr = is_push ? (ssp - XLEN'(BYTES)) : ssp;
        acc_mis  = (acc_addr[AL-1:0] != '0);
    end
endmodule

// File: rtl/sstk_ctrl.sv
module sstk_ctrl
    import sstk_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_req,
    input  logic [4:0]      src_idx,
    input  logic [XLEN-1:0] src_val,
    input  logic            en,
    input  logic [XLEN-1:0] acc_addr,
    input  logic            acc_mis,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            mem_rsp,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_err,
    output logic [XLEN-1:0] ssp,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output fault_t          fault,
    output logic [XLEN-1:0] fault_addr,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata
);
    localparam int BYTES = XLEN / 8;

    state_e          state;
    logic [XLEN-1:0] cmp_val;

    assign busy = (state == ST_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ssp        <= '0;
            done       <= 1'b0;
            result     <= '0;
            fault      <= '0;
            fault_addr <= '0;
            mem_req    <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            cmp_val    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (op_req != '0) begin
                        fault      <= '0;
                        result     <= '0;
                        fault_addr <= '0;
                        if (op_req[OP_RDPTR]) begin
                            result <= en ? ssp : '0;
                            done   <= 1'b1;
                        end else if (!link_reg_ok(src_idx)) begin
                            fault.illegal <= 1'b1;
                            done          <= 1'b1;
                        end else if (!en) begin
                            done <= 1'b1;
                        end else if (acc_mis) begin
                            fault.access <= 1'b1;
                            fault_addr   <= acc_addr;
                            done         <= 1'b1;
                        end else begin
                            mem_req   <= 1'b1;
                            mem_we    <= op_req[OP_PUSH];
                            mem_addr  <= acc_addr;
                            mem_wdata <= op_req[OP_PUSH] ? src_val : '0;
                            cmp_val   <= src_val;
                            state     <= ST_WAIT;
                        end
                    end else if (csr_we) begin
                        ssp <= csr_wdata;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp) begin
                        mem_req <= 1'b0;
                        mem_we  <= 1'b0;
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                        if (mem_err) begin
                            fault.access <= 1'b1;
                            fault_addr   <= mem_addr;
                        end else if (mem_we) begin
                            ssp <= mem_addr;
                        end else if (mem_rdata == cmp_val) begin
                            ssp <= ssp + XLEN'(BYTES);
                        end else begin
                            fault.swchk <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sstk_unit.sv
module sstk_unit
    import sstk_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      op_req,
    input  logic [4:0]      src_idx,
    input  logic [XLEN-1:0] src_val,
    input  logic [1:0]      priv,
    input  logic            menv_sse,
    input  logic            senv_sse,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic [XLEN-1:0] ssp_o,
    output logic            fault_access,
    output logic            fault_swchk,
    output logic            fault_illegal,
    output logic [XLEN-1:0] fault_addr,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_rsp,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_err
);
    logic            en;
    logic [XLEN-1:0] acc_addr;
    logic            acc_mis;
    fault_t          fault;

    sstk_enable #(.HAS_SMODE(HAS_SMODE)) enable_i (
        .priv     (priv),
        .menv_sse (menv_sse),
        .senv_sse (senv_sse),
        .en       (en)
    );

    sstk_addr #(.XLEN(XLEN)) addr_i (
        .is_push  (op_req[OP_PUSH]),
        .ssp      (ssp_o),
        .acc_addr (acc_addr),
        .acc_mis  (acc_mis)
    );

    sstk_ctrl #(.XLEN(XLEN)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .op_req     (op_req),
        .src_idx    (src_idx),
        .src_val    (src_val),
        .en         (en),
        .acc_addr   (acc_addr),
        .acc_mis    (acc_mis),
        .csr_we     (csr_we),
        .csr_wdata  (csr_wdata),
        .mem_rsp    (mem_rsp),
        .mem_rdata  (mem_rdata),
        .mem_err    (mem_err),
        .ssp        (ssp_o),
        .busy       (busy),
        .done       (done),
        .result     (result),
        .fault      (fault),
        .fault_addr (fault_addr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    assign fault_access  = fault.access;
    assign fault_swchk   = fault.swchk;
    assign fault_illegal = fault.illegal;
endmodule

// File: rtl/sstk_unit_chk.sv
module sstk_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      op_req,
    input logic [1:0]      priv,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] ssp_o,
    input logic            fault_access,
    input logic            fault_swchk,
    input logic            fault_illegal,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_rsp
);
    localparam int BYTES = XLEN / 8;
    localparam int AL    = $clog2(BYTES);

    logic any_fault;
    assign any_fault = fault_access | fault_swchk | fault_illegal;

    // R9: request held stable until answered
    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_rsp |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R9: completion only reported when not busy
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6: no misaligned address ever reaches memory
    a_r6_aligned_req: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[AL-1:0] == '0));

    // R1: machine mode never reaches memory
    a_r1_machine_off: assert property (@(posedge clk) disable iff (rst)
        (op_req != 3'b000) && !busy && (priv == 2'b11) |=> !mem_req);

    // R4: successful push moves the pointer down one word
    a_r4_push_step: assert property (@(posedge clk) disable iff (rst)
        done && !any_fault && $past(mem_req && mem_we) |-> ssp_o == $past(ssp_o) - XLEN'(BYTES));

    // R5: successful pop-check moves the pointer up one word
    a_r5_pop_step: assert property (@(posedge clk) disable iff (rst)
        done && !any_fault && $past(mem_req && !mem_we) |-> ssp_o == $past(ssp_o) + XLEN'(BYTES));

    // R8: any fault leaves the pointer alone
    a_r8_fault_keeps_ssp: assert property (@(posedge clk) disable iff (rst)
        done && any_fault |-> ssp_o == $past(ssp_o));

    // R7: at most one fault kind at a time
    a_r7_single_fault: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot0({fault_access, fault_swchk, fault_illegal}));
endmodule

bind sstk_unit sstk_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .op_req        (op_req),
    .priv          (priv),
    .busy          (busy),
    .done          (done),
    .ssp_o         (ssp_o),
    .fault_access  (fault_access),
    .fault_swchk   (fault_swchk),
    .fault_illegal (fault_illegal),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_rsp       (mem_rsp)
);

// File: tb/sstk_unit_tb_top.sv
module sstk_unit_tb_top;
    localparam int XLEN  = 32;
    localparam int BYTES = XLEN / 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      op_req = '0;
    logic [4:0]      src_idx = '0;
    logic [XLEN-1:0] src_val = '0;
    logic [1:0]      priv = 2'b11;
    logic            menv_sse = 1'b0;
    logic            senv_sse = 1'b0;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            busy, done, fault_access, fault_swchk, fault_illegal;
    logic [XLEN-1:0] result, ssp_o, fault_addr;
    logic            mem_req, mem_we;
    logic [XLEN-1:0] mem_addr, mem_wdata;
    logic            mem_rsp = 1'b0;
    logic [XLEN-1:0] mem_rdata = '0;
    logic            mem_err = 1'b0;

    always #5 clk = ~clk;

    sstk_unit #(.XLEN(XLEN), .HAS_SMODE(1'b1)) dut_i (.*);

    typedef struct {
        logic [XLEN-1:0] result;
        logic [XLEN-1:0] ssp;
        logic            acc;
        logic            swchk;
        logic            ill;
        logic [XLEN-1:0] faddr;
        logic            touches;
        string           tag;
    } exp_t;

    exp_t            sb_q[$];
    int              tests = 0;
    int              fails = 0;
    logic [XLEN-1:0] ref_ssp = '0;
    logic [XLEN-1:0] mem_arr [0:63];
    logic            inject_err = 1'b0;
    int              acc_cnt = 0;
    int              done_cnt = 0;
    logic [XLEN-1:0] last_wr_addr = '0;
    logic [XLEN-1:0] last_wr_data = '0;

    task automatic chk(input logic ok, input string tag, input logic [XLEN-1:0] got,
                       input logic [XLEN-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // memory model: answers one cycle after a request is seen
    initial begin
        for (int i = 0; i < 64; i++) mem_arr[i] = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp) begin
                mem_rsp = 1'b0;
                mem_err = 1'b0;
            end else if (mem_req) begin
                acc_cnt++;
                mem_rsp = 1'b1;
                mem_err = inject_err;
                mem_rdata = mem_arr[(mem_addr >> 2) & 63];
                if (mem_we && !inject_err) begin
                    mem_arr[(mem_addr >> 2) & 63] = mem_wdata;
                    last_wr_addr = mem_addr;
                    last_wr_data = mem_wdata;
                end
            end
        end
    end

    // monitor: compares each completion against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                exp_t e;
                done_cnt++;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk(result == e.result, {e.tag, " result"}, result, e.result);
                    chk(ssp_o == e.ssp, {e.tag, " ssp"}, ssp_o, e.ssp);
                    chk(fault_access == e.acc, {e.tag, " fault_access"}, XLEN'(fault_access), XLEN'(e.acc));
                    chk(fault_swchk == e.swchk, {e.tag, " fault_swchk"}, XLEN'(fault_swchk), XLEN'(e.swchk));
                    chk(fault_illegal == e.ill, {e.tag, " fault_illegal"}, XLEN'(fault_illegal), XLEN'(e.ill));
                    if (e.acc)
                        chk(fault_addr == e.faddr, {e.tag, " fault_addr"}, fault_addr, e.faddr);
                    chk((acc_cnt != 0) == e.touches, {e.tag, " memory access"}, XLEN'(acc_cnt), XLEN'(e.touches));
                end
            end
        end
    end

    function automatic logic ref_en(input logic [1:0] p, input logic m, input logic s);
        case (p)
            2'b01:   return m;
            2'b00:   return s;
            default: return 1'b0;
        endcase
    endfunction

    // driver: computes the expected outcome, queues it, runs the operation
    task automatic do_op(input logic [2:0] op, input logic [4:0] idx, input logic [XLEN-1:0] val,
                         input logic [1:0] p, input logic m, input logic s, input string tag,
                         input logic poke_busy = 1'b0);
        exp_t            e;
        logic            en;
        logic [XLEN-1:0] a;
        en = ref_en(p, m, s);
        e.result = '0; e.acc = 0; e.swchk = 0; e.ill = 0; e.faddr = '0; e.touches = 0; e.tag = tag;
        if (op[2]) begin
            e.result = en ? ref_ssp : '0;
        end else if (!(idx == 5'd1 || idx == 5'd5)) begin
            e.ill = 1;
        end else if (en) begin
            a = op[0] ? ref_ssp - XLEN'(BYTES) : ref_ssp;
            if (a[1:0] != 2'b00) begin
                e.acc = 1; e.faddr = a;
            end else begin
                e.touches = 1;
                if (inject_err) begin
                    e.acc = 1; e.faddr = a;
                end else if (op[0]) begin
                    ref_ssp = a;
                end else if (mem_arr[(a >> 2) & 63] == val) begin
                    ref_ssp = ref_ssp + XLEN'(BYTES);
                end else begin
                    e.swchk = 1;
                end
            end
        end
        e.ssp = ref_ssp;
        sb_q.push_back(e);
        @(negedge clk);
        acc_cnt = 0;
        op_req = op; src_idx = idx; src_val = val; priv = p; menv_sse = m; senv_sse = s;
        @(negedge clk);
        if (poke_busy && busy) begin
            // R9/R10: a second request and a pointer write while busy are ignored
            op_req = 3'b100; csr_we = 1'b1; csr_wdata = 32'h0000_0200;
            @(negedge clk);
            csr_we = 1'b0;
        end
        op_req = '0;
        for (int k = 0; k < 100 && !done; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic csr_write(input logic [XLEN-1:0] v, input string tag);
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = v;
        @(negedge clk);
        csr_we = 1'b0;
        ref_ssp = v;
        chk(ssp_o == v, tag, ssp_o, v);
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(ssp_o == '0, "R10 reset ssp", ssp_o, '0);
        chk(!busy && !done && !mem_req, "R10 reset controls", XLEN'({busy, done, mem_req}), '0);

        csr_write(32'h0000_0100, "R10 pointer write while idle");

        // R1/R3: read-pointer across privilege levels
        do_op(3'b100, 5'd0, '0, 2'b01, 1'b1, 1'b0, "R3 rdptr supervisor enabled");
        do_op(3'b100, 5'd7, '0, 2'b11, 1'b1, 1'b1, "R1 rdptr machine disabled");
        do_op(3'b100, 5'd0, '0, 2'b00, 1'b1, 1'b0, "R1 rdptr user senv clear");
        do_op(3'b100, 5'd0, '0, 2'b00, 1'b0, 1'b1, "R1 rdptr user senv set");
        do_op(3'b100, 5'd0, '0, 2'b01, 1'b0, 1'b1, "R1 rdptr supervisor menv clear");

        // R4: pushes
        do_op(3'b001, 5'd1, 32'hCAFE_0001, 2'b01, 1'b1, 1'b0, "R4 push x1");
        chk(last_wr_addr == 32'h0000_00FC, "R4 push address", last_wr_addr, 32'h0000_00FC);
        chk(last_wr_data == 32'hCAFE_0001, "R4 push data", last_wr_data, 32'hCAFE_0001);
        do_op(3'b001, 5'd5, 32'hBEEF_0002, 2'b00, 1'b0, 1'b1, "R4 push x5 user");

        // R5: pop-check match, mismatch
        do_op(3'b010, 5'd5, 32'hBEEF_0002, 2'b01, 1'b1, 1'b0, "R5 popchk match");
        do_op(3'b010, 5'd1, 32'h1234_5678, 2'b01, 1'b1, 1'b0, "R5 popchk mismatch");
        do_op(3'b010, 5'd1, 32'hCAFE_0001, 2'b01, 1'b1, 1'b0, "R11 popchk closes round trip");
        chk(ssp_o == 32'h0000_0100, "R11 round trip ssp", ssp_o, 32'h0000_0100);

        // R2: disabled operations
        do_op(3'b001, 5'd1, 32'h1111_1111, 2'b11, 1'b1, 1'b1, "R2 push machine mode");
        do_op(3'b010, 5'd5, 32'h2222_2222, 2'b00, 1'b1, 1'b0, "R2 popchk user disabled");

        // R7: illegal source register, with and without enable
        do_op(3'b001, 5'd2, 32'h3333_3333, 2'b01, 1'b1, 1'b0, "R7 push x2");
        do_op(3'b010, 5'd0, 32'h3333_3333, 2'b11, 1'b0, 1'b0, "R7 popchk x0 disabled");

        // R6: misaligned pointer
        csr_write(32'h0000_0102, "R10 pointer write misaligned value");
        do_op(3'b001, 5'd1, 32'h4444_4444, 2'b01, 1'b1, 1'b0, "R6 push misaligned");
        do_op(3'b010, 5'd1, 32'h4444_4444, 2'b01, 1'b1, 1'b0, "R6 popchk misaligned");

        // R8: memory error
        csr_write(32'h0000_0100, "R10 pointer restore");
        inject_err = 1'b1;
        do_op(3'b001, 5'd1, 32'h5555_5555, 2'b01, 1'b1, 1'b0, "R8 push memory error");
        do_op(3'b010, 5'd5, 32'h5555_5555, 2'b01, 1'b1, 1'b0, "R8 popchk memory error");
        inject_err = 1'b0;

        // R9/R10: request and pointer write during a busy push are ignored
        done_cnt = 0;
        do_op(3'b001, 5'd1, 32'h6666_6666, 2'b01, 1'b1, 1'b0, "R9 push with busy poke", 1'b1);
        chk(done_cnt == 1, "R9 single completion", XLEN'(done_cnt), 1);
        chk(ssp_o == 32'h0000_00FC, "R10 pointer write ignored while busy", ssp_o, 32'h0000_00FC);

        chk(sb_q.size() == 0, "R9 scoreboard drained", XLEN'(sb_q.size()), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule